// File: doc/BRIEF.md
# Video output formatter for 4:2:2 component streams

The formatter receives a decoded 4:2:2 luma/chroma sample stream and presents it in one of two output forms. In the parallel form, an 8-bit luma bus and an 8-bit chroma bus each carry one value per sample period. The chroma bus alternates the two colour-difference values, and separate horizontal and vertical strobes mark lines and fields. In the multiplexed form, a single 8-bit bus runs at twice the sample rate. It interleaves chroma and luma and carries embedded timing reference words at the start and end of each active region of a line.

An internal timing generator counts ticks of the double-rate clock, sample periods within a line, and lines within an interlaced frame. Static configuration inputs select either the 525-line or the 625-line standard, the output form, and a clamp that raises sub-black luma to black level. A progressive-source flag overrides the form select and always gives the parallel output. The upstream source holds each sample for two clocks. It places a blue-difference value on the chroma input in even active sample periods and a red-difference value in odd ones, counting from the first active sample.

Top module: `vid_out_fmt`

## Requirements
- R1: While rst_ni is low, y_o is 0x10, c_o is 0x80, and hd_o and vd_o are 0.
- R2: The clock runs at two ticks per sample period, and a line has LINE_525 sample periods (std625_i=0) or LINE_625 (std625_i=1). hd_o is high for the first HD_W sample periods of every line. Every output reflects the position and inputs of the previous clock.
- R3: A frame has FRAME_525 or FRAME_625 lines, numbered from 0. Lines below F0_525/F0_625 form field 0 and the rest form field 1. vd_o is high for the whole line whose index within its field equals vd_line_i.
- R4: In the parallel form, during active samples, y_o equals y_i (subject to R6) and c_o equals c_i.
- R5: Active samples are the last ACT_SMP sample periods of a line, on lines whose index within the field lies in [VBLK, VBLK+ACTL). Outside them, the parallel form gives y_o=0x10 and c_o=0x80.
- R6: With clamp_en_i=1, an active luma value below 0x10 is sent as 0x10; with clamp_en_i=0 it passes unchanged. This applies in both forms.
- R7: In the multiplexed form, y_o carries FF 00 00 XY on the first four ticks of every line (end-of-active code, H=1). It carries the same pattern on the four ticks just before the first active sample (start-of-active code, H=0).
- R8: In the multiplexed form, an active sample period gives chroma on its first tick and luma on its second tick, so the bus order is Cb, Y, Cr, Y. c_o stays at 0x80.
- R9: In the multiplexed form, an active value of 0x00 is sent as 0x01 and 0xFF as 0xFE.
- R10: In the multiplexed form, outside codes and active samples, y_o is 0x80 on the first tick of a sample period and 0x10 on the second tick.
- R11: XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}. Bit 7 is the first bit. F is the field number and V is 1 on lines outside the active line range.
- R12: With prog_i=1, the output is in the parallel form whatever the value of fmt656_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock, two ticks per sample period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| std625_i | input | 1 | 1 selects the 625-line standard, 0 selects the 525-line standard |
| fmt656_i | input | 1 | 1 selects the multiplexed form with embedded codes |
| prog_i | input | 1 | Progressive source flag; forces the parallel form |
| clamp_en_i | input | 1 | Raises sub-black luma to 0x10 |
| vd_line_i | input | VW | Line index within a field at which vd_o is raised |
| y_i | input | 8 | Luma sample, held for two ticks |
| c_i | input | 8 | Chroma sample (Cb on even active samples, Cr on odd) |
| y_o | output | 8 | Parallel luma, or the multiplexed bus |
| c_o | output | 8 | Parallel chroma; 0x80 in the multiplexed form |
| hd_o | output | 1 | Line strobe |
| vd_o | output | 1 | Field strobe |

## Verification
The assertions check on every cycle that the end-of-active code begins with 0xFF and that the XY H bit matches the code type. They also check that multiplexed payload never takes a reserved value and that the clamp floor holds. Further cycle-by-cycle checks are that chroma is parked in the multiplexed form and that parallel blanking gives black. The bench scenarios are needed to show the rest: the line and frame lengths for each standard, the field split and the vd_o placement, and the F/V bits across a whole frame. The same applies to the Cb/Y/Cr/Y ordering against real input data and to the progressive override under both settings of the form select.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  localparam logic [7:0] BLK_Y = 8'h10;
  localparam logic [7:0] MID_C = 8'h80;

  function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // keep payload off the reserved code values
  function automatic logic [7:0] no_code(input logic [7:0] d);
    if (d == 8'h00) return 8'h01;
    if (d == 8'hFF) return 8'hFE;
    return d;
  endfunction
endpackage

// File: rtl/vfmt_timing.sv
module vfmt_timing #(
  parameter int LINE_525  = 858,
  parameter int LINE_625  = 864,
  parameter int ACT_SMP   = 720,
  parameter int FRAME_525 = 525,
  parameter int FRAME_625 = 625,
  parameter int F0_525    = 263,
  parameter int F0_625    = 312,
  parameter int VBLK_525  = 19,
  parameter int VBLK_625  = 22,
  parameter int ACTL_525  = 240,
  parameter int ACTL_625  = 288,
  parameter int HD_W      = 64,
  parameter int HW        = 10,
  parameter int VW        = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std625_i,
  input  logic [VW-1:0] vd_line_i,
  output logic          ph_o,
  output logic          hact_o,
  output logic          vact_o,
  output logic          fld_o,
  output logic          code_o,
  output logic [1:0]    code_idx_o,
  output logic          code_eav_o,
  output logic          hd_o,
  output logic          vd_o
);
  localparam logic [HW-1:0] LL_A = HW'(LINE_525 - 1);
  localparam logic [HW-1:0] LL_B = HW'(LINE_625 - 1);
  localparam logic [HW-1:0] AS_A = HW'(LINE_525 - ACT_SMP);
  localparam logic [HW-1:0] AS_B = HW'(LINE_625 - ACT_SMP);
  localparam logic [HW-1:0] HDW  = HW'(HD_W);
  localparam logic [VW-1:0] FL_A = VW'(FRAME_525 - 1);
  localparam logic [VW-1:0] FL_B = VW'(FRAME_625 - 1);
  localparam logic [VW-1:0] F0_A = VW'(F0_525);
  localparam logic [VW-1:0] F0_B = VW'(F0_625);
  localparam logic [VW-1:0] VB_A = VW'(VBLK_525);
  localparam logic [VW-1:0] VB_B = VW'(VBLK_625);
  localparam logic [VW-1:0] VE_A = VW'(VBLK_525 + ACTL_525);
  localparam logic [VW-1:0] VE_B = VW'(VBLK_625 + ACTL_625);

  logic          ph_q;
  logic [HW-1:0] h_q;
  logic [VW-1:0] ln_q;
  logic [HW-1:0] line_last, act_start;
  logic [VW-1:0] frame_last, f0_lines, vb, ve, loc_ln;
  logic          eav, sav;

  always_comb begin
    line_last  = std625_i ? LL_B : LL_A;
    act_start  = std625_i ? AS_B : AS_A;
    frame_last = std625_i ? FL_B : FL_A;
    f0_lines   = std625_i ? F0_B : F0_A;
    vb         = std625_i ? VB_B : VB_A;
    ve         = std625_i ? VE_B : VE_A;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b0;
      h_q  <= '0;
      ln_q <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        if (h_q >= line_last) begin
          h_q  <= '0;
          ln_q <= (ln_q >= frame_last) ? '0 : ln_q + 1'b1;
        end else begin
          h_q <= h_q + 1'b1;
        end
      end
    end
  end

  assign fld_o  = ln_q >= f0_lines;
  assign loc_ln = fld_o ? ln_q - f0_lines : ln_q;
  assign vact_o = (loc_ln >= vb) && (loc_ln < ve);
  assign hact_o = h_q >= act_start;
  assign eav    = h_q < HW'(2);
  assign sav    = (h_q >= act_start - HW'(2)) && (h_q < act_start);
  assign code_o = eav | sav;
  assign code_eav_o = eav;
  // word index: sample offset inside the code, then tick phase
  assign code_idx_o = {h_q[0] ^ (~eav & act_start[0]), ph_q};
  assign ph_o   = ph_q;
  assign hd_o   = h_q < HDW;
  assign vd_o   = loc_ln == vd_line_i;
endmodule

// File: rtl/vfmt_pixel.sv
module vfmt_pixel
  import vfmt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mux_i,
  input  logic       clamp_i,
  input  logic [7:0] y_i,
  input  logic [7:0] c_i,
  input  logic       ph_i,
  input  logic       hact_i,
  input  logic       vact_i,
  input  logic       fld_i,
  input  logic       code_i,
  input  logic [1:0] code_idx_i,
  input  logic       code_eav_i,
  input  logic       hd_i,
  input  logic       vd_i,
  output logic [7:0] y_o,
  output logic [7:0] c_o,
  output logic       hd_o,
  output logic       vd_o
);
  logic       act;
  logic [7:0] y_cl, y_n, c_n;

  assign act = hact_i & vact_i;

  always_comb begin
    y_cl = (clamp_i && (y_i < BLK_Y)) ? BLK_Y : y_i;
    y_n  = BLK_Y;
    c_n  = MID_C;
    if (!mux_i) begin
      if (act) begin
        y_n = y_cl;
        c_n = c_i;
      end
    end else if (code_i) begin
      unique case (code_idx_i)
        2'd0:    y_n = 8'hFF;
        2'd3:    y_n = trs_word(fld_i, ~vact_i, code_eav_i);
        default: y_n = 8'h00;
      endcase
    end else if (act) begin
      y_n = no_code(ph_i ? y_cl : c_i);
    end else begin
      y_n = ph_i ? BLK_Y : MID_C;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o  <= BLK_Y;
      c_o  <= MID_C;
      hd_o <= 1'b0;
      vd_o <= 1'b0;
    end else begin
      y_o  <= y_n;
      c_o  <= c_n;
      hd_o <= hd_i;
      vd_o <= vd_i;
    end
  end

  a_r7_eav_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_i && code_i && code_eav_i && code_idx_i == 2'd0) |=> (y_o == 8'hFF));

  a_r11_xy_hbit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_i && code_i && code_idx_i == 2'd3) |=> (y_o[7] && (y_o[4] == $past(code_eav_i))));

  a_r9_payload_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_i && !code_i && act) |=> (y_o != 8'h00 && y_o != 8'hFF));

  a_r6_clamp_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mux_i && clamp_i && act) |=> (y_o >= BLK_Y));

  a_r8_c_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_i |=> (c_o == MID_C));

  a_r5_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mux_i && !act) |=> (y_o == BLK_Y && c_o == MID_C));
endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt #(
  parameter int LINE_525  = 858,
  parameter int LINE_625  = 864,
  parameter int ACT_SMP   = 720,
  parameter int FRAME_525 = 525,
  parameter int FRAME_625 = 625,
  parameter int F0_525    = 263,
  parameter int F0_625    = 312,
  parameter int VBLK_525  = 19,
  parameter int VBLK_625  = 22,
  parameter int ACTL_525  = 240,
  parameter int ACTL_625  = 288,
  parameter int HD_W      = 64,
  localparam int HW = $clog2((LINE_625 > LINE_525) ? LINE_625 : LINE_525),
  localparam int VW = $clog2((FRAME_625 > FRAME_525) ? FRAME_625 : FRAME_525)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std625_i,
  input  logic          fmt656_i,
  input  logic          prog_i,
  input  logic          clamp_en_i,
  input  logic [VW-1:0] vd_line_i,
  input  logic [7:0]    y_i,
  input  logic [7:0]    c_i,
  output logic [7:0]    y_o,
  output logic [7:0]    c_o,
  output logic          hd_o,
  output logic          vd_o
);
  logic       mux;
  logic       ph, hact, vact, fld, code, code_eav, hd, vd;
  logic [1:0] code_idx;

  assign mux = fmt656_i & ~prog_i;

  vfmt_timing #(
    .LINE_525(LINE_525), .LINE_625(LINE_625), .ACT_SMP(ACT_SMP),
    .FRAME_525(FRAME_525), .FRAME_625(FRAME_625),
    .F0_525(F0_525), .F0_625(F0_625),
    .VBLK_525(VBLK_525), .VBLK_625(VBLK_625),
    .ACTL_525(ACTL_525), .ACTL_625(ACTL_625),
    .HD_W(HD_W), .HW(HW), .VW(VW)
  ) u_tim (
    .clk_i(clk_i), .rst_ni(rst_ni), .std625_i(std625_i), .vd_line_i(vd_line_i),
    .ph_o(ph), .hact_o(hact), .vact_o(vact), .fld_o(fld),
    .code_o(code), .code_idx_o(code_idx), .code_eav_o(code_eav),
    .hd_o(hd), .vd_o(vd)
  );

  vfmt_pixel u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni), .mux_i(mux), .clamp_i(clamp_en_i),
    .y_i(y_i), .c_i(c_i), .ph_i(ph), .hact_i(hact), .vact_i(vact), .fld_i(fld),
    .code_i(code), .code_idx_i(code_idx), .code_eav_i(code_eav),
    .hd_i(hd), .vd_i(vd),
    .y_o(y_o), .c_o(c_o), .hd_o(hd_o), .vd_o(vd_o)
  );
endmodule

// File: tb/sim_vid_out_fmt.sv
module sim_vid_out_fmt;
  localparam int L_A = 20, L_B = 22, ACT = 8;
  localparam int FR_A = 11, FR_B = 13, F0_A = 6, F0_B = 7;
  localparam int VB_A = 1, VB_B = 2, AL_A = 4, AL_B = 4, HDW = 3;
  localparam int NSEG = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni, std625, fmt656, prog, clamp;
  logic [3:0] vd_line;
  logic [7:0] y_in, c_in;
  logic [7:0] y_o, c_o;
  logic       hd_o, vd_o;

  vid_out_fmt #(
    .LINE_525(L_A), .LINE_625(L_B), .ACT_SMP(ACT),
    .FRAME_525(FR_A), .FRAME_625(FR_B), .F0_525(F0_A), .F0_625(F0_B),
    .VBLK_525(VB_A), .VBLK_625(VB_B), .ACTL_525(AL_A), .ACTL_625(AL_B), .HD_W(HDW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .std625_i(std625), .fmt656_i(fmt656),
    .prog_i(prog), .clamp_en_i(clamp), .vd_line_i(vd_line),
    .y_i(y_in), .c_i(c_in), .y_o(y_o), .c_o(c_o), .hd_o(hd_o), .vd_o(vd_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_ph, m_h, m_ln;
  int p_ph, p_h, p_ln, p_vd;
  bit p_std, p_fmt, p_prog, p_clamp;
  logic [7:0] p_y, p_c;

  function automatic logic [7:0] lim(input logic [7:0] d);
    if (d == 8'h00) return 8'h01;
    if (d == 8'hFF) return 8'hFE;
    return d;
  endfunction

  function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk8(input string tag, input string what, input logic [7:0] a, input logic [7:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h (line %0d smp %0d tick %0d)", tag, what, a, e, p_ln, p_h, p_ph);
    end
  endtask

  task automatic chk1(input string tag, input string what, input logic a, input logic e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b (line %0d smp %0d)", tag, what, a, e, p_ln, p_h);
    end
  endtask

  // expected outputs for the previous clock's position and inputs
  task automatic compare();
    int ls, as, f0, vb, al, loc, idx;
    bit fld, vact, hact, act, mux, eav, sav;
    logic [7:0] yc, raw, ey, ec;
    string ty, tc;
    ls  = p_std ? L_B : L_A;
    f0  = p_std ? F0_B : F0_A;
    vb  = p_std ? VB_B : VB_A;
    al  = p_std ? AL_B : AL_A;
    as  = ls - ACT;
    fld = p_ln >= f0;
    loc = fld ? p_ln - f0 : p_ln;
    vact = (loc >= vb) && (loc < vb + al);
    hact = p_h >= as;
    act  = vact && hact;
    mux  = p_fmt && !p_prog;
    yc   = (p_clamp && p_y < 8'h10) ? 8'h10 : p_y;
    ec = 8'h80;
    tc = "R8";
    if (!mux) begin
      tc = "R4";
      if (act) begin
        ey = yc; ec = p_c;
        ty = (p_clamp && p_y < 8'h10) ? "R6" : (p_fmt ? "R12" : "R4");
        if (p_fmt) tc = "R12";
      end else begin
        ey = 8'h10; ty = "R5"; tc = "R5";
      end
    end else begin
      eav = p_h < 2;
      sav = (p_h >= as - 2) && (p_h < as);
      if (eav || sav) begin
        idx = ((eav ? p_h : p_h - (as - 2)) % 2) * 2 + p_ph;
        case (idx)
          0: ey = 8'hFF;
          3: ey = xy(fld, !vact, eav);
          default: ey = 8'h00;
        endcase
        ty = (idx == 3) ? "R11" : "R7";
      end else if (act) begin
        raw = p_ph ? yc : p_c;
        ey = lim(raw);
        ty = (raw == 8'h00 || raw == 8'hFF) ? "R9" : ((p_clamp && p_ph && p_y < 8'h10) ? "R6" : "R8");
      end else begin
        ey = p_ph ? 8'h10 : 8'h80;
        ty = "R10";
      end
    end
    chk8(ty, "y_o", y_o, ey);
    chk8(tc, "c_o", c_o, ec);
    chk1("R2", "hd_o", hd_o, p_h < HDW);
    chk1("R3", "vd_o", vd_o, loc == p_vd);
  endtask

  task automatic capture();
    p_ph = m_ph; p_h = m_h; p_ln = m_ln;
    p_std = std625; p_fmt = fmt656; p_prog = prog; p_clamp = clamp;
    p_vd = int'(vd_line); p_y = y_in; p_c = c_in;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    if (m_ph == 1) begin
      if (m_h >= (p_std ? L_B : L_A) - 1) begin
        m_h = 0;
        m_ln = (m_ln >= (p_std ? FR_B : FR_A) - 1) ? 0 : m_ln + 1;
      end else m_h++;
    end
    m_ph ^= 1;
  endtask

  task automatic drive_sample();
    int r;
    r = int'($urandom % 8);
    case (r)
      0: y_in = 8'h00;
      1: y_in = 8'hFF;
      2: y_in = 8'h0F;
      3: y_in = 8'h10;
      4: y_in = 8'h05;
      default: y_in = 8'($urandom);
    endcase
    r = int'($urandom % 6);
    case (r)
      0: c_in = 8'h00;
      1: c_in = 8'hFF;
      default: c_in = 8'($urandom);
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_ni = 1'b0; std625 = 0; fmt656 = 1; prog = 0; clamp = 0; vd_line = 4'd2;
    y_in = 8'h00; c_in = 8'hFF;
    #23;
    // R1: reset values while rst_ni is low
    chk8("R1", "y_o", y_o, 8'h10);
    chk8("R1", "c_o", c_o, 8'h80);
    chk1("R1", "hd_o", hd_o, 1'b0);
    chk1("R1", "vd_o", vd_o, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_ph = 0; m_h = 0; m_ln = 0;
    for (int s = 0; s < NSEG; s++) begin
      int ticks;
      case (s)
        0: begin std625 = 0; fmt656 = 0; prog = 0; clamp = 0; vd_line = 4'd0; end
        1: begin std625 = 0; fmt656 = 0; prog = 0; clamp = 1; vd_line = 4'd3; end
        2: begin std625 = 0; fmt656 = 1; prog = 0; clamp = 0; vd_line = 4'd1; end
        3: begin std625 = 0; fmt656 = 1; prog = 0; clamp = 1; vd_line = 4'd4; end
        4: begin std625 = 1; fmt656 = 1; prog = 0; clamp = 0; vd_line = 4'd5; end
        5: begin std625 = 1; fmt656 = 0; prog = 0; clamp = 1; vd_line = 4'd6; end
        6: begin std625 = 1; fmt656 = 1; prog = 1; clamp = 0; vd_line = 4'd2; end
        7: begin std625 = 0; fmt656 = 1; prog = 1; clamp = 1; vd_line = 4'd0; end
        default: begin
          std625 = 1'($urandom); fmt656 = 1'($urandom); prog = ($urandom % 4) == 0;
          clamp = 1'($urandom); vd_line = 4'($urandom % 7);
        end
      endcase
      ticks = 2 * 2 * (std625 ? L_B * FR_B : L_A * FR_A);
      for (int t = 0; t < ticks; t++) begin
        if (m_ph == 0) drive_sample();
        capture();
        step();
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule